// File: doc/BRIEF.md
# Transition-Coded Serial Packet Transmitter

This block turns a packet request into a serial bit stream on a single line. A request gives an 8-bit packet identifier and a payload byte count. The block then emits, in a fixed order, a synchronization byte, the identifier, the payload bytes, and a 16-bit check value computed over the payload. Each bit leaves the block only on a cycle where `bit_en` is high, so one clock domain can drive any serial bit period. When the request is accepted, the sync byte and identifier are captured. Payload bytes are pulled one at a time through a valid/ready stream input.

The line uses transition coding. A 0 bit flips the line level and a 1 bit leaves it where it is. The line rests high after reset. Between packets the line holds whatever level the last packet left, and the next packet continues from that level. A payload count above the limit is refused with a one-cycle error pulse, and nothing goes out. Back-pressure on the byte stream works like this. `in_ready` is raised only when the shifter has emptied a byte and another payload byte is due. A byte is taken on any cycle where `in_valid` and `in_ready` are both high. While `in_valid` stays low, transmission pauses, and `bit_en` pulses have no effect. A sender may hold `in_valid` high early without risk, because no byte is taken until `in_ready` is high.

Top module: `bitstream_pkt_tx`

## Requirements
- R1: After reset, `line_out` is 1 and `busy`, `done`, `in_ready` and `len_err` are 0.
- R2: Each transmitted 0 bit inverts `line_out` and each 1 bit keeps it. The line changes only in the cycle after a `bit_en` pulse that consumes a bit.
- R3: The first 8 bits of every packet are the sync value 8'b00000001, least significant bit first, so the bits are 1 followed by seven 0s.
- R4: The next 8 bits are the identifier latched at `start`, least significant bit first.
- R5: Payload bytes follow in the order they were accepted, each least significant bit first. Exactly `len` handshakes take place per packet.
- R6: The last 16 bits are the ones-complement of a CRC over the payload bits only, sent least significant bit first. The CRC uses polynomial x^16+x^15+x^2+1 in reflected form 0xA001 and is preset to 0xFFFF. With an empty payload this gives sixteen 0 bits.
- R7: A `start` with `len` greater than 64 produces a single-cycle `len_err` pulse. No bits are sent, `busy` stays 0, and the line is unchanged.
- R8: `done` pulses for exactly one cycle together with the fall of `busy`, in the cycle after the last CRC bit is consumed.
- R9: The line level left by one packet is the starting level of the next packet.
- R10: `start` is ignored while a packet is in progress. It raises no error and does not disturb the stream.
- R11: When a payload byte is due and `in_valid` is low, `in_ready` stays high and `bit_en` pulses consume no bits. Transmission resumes after the byte is accepted.
- R12: A zero-length payload is accepted and sends sync, identifier and CRC only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a packet (sampled while idle) |
| pid | input | 8 | Packet identifier for the request |
| len | input | LEN_W (7) | Payload byte count for the request |
| bit_en | input | 1 | Serial bit strobe |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block can take a payload byte |
| line_out | output | 1 | Transition-coded serial line |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| len_err | output | 1 | One-cycle pulse on an over-long request |

## Verification
The hardest state to reach from the ports is a byte underrun. In that state the shifter has emptied after the identifier or a payload byte, and `bit_en` pulses keep arriving while `in_valid` is low. The stimulus withholds the valid signal from the start of a packet. After the identifier it sends several bit strobes and checks that the line stays frozen and that `in_ready` stays high. It then releases the byte and confirms that the rest of the stream is bit-exact. A second hard case is a fresh `start` with an illegal length arriving in the middle of a packet. The stimulus injects it between two bit strobes and then checks both for silence on `len_err` and for an unbroken bit stream.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_PID,
    ST_LOAD,
    ST_DATA,
    ST_CRC
  } tx_state_t;

  localparam logic [7:0]  SYNC_PATTERN  = 8'h01;
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;
  localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
endpackage

// File: rtl/pkt_crc16.sv
module pkt_crc16 #(
  parameter int          CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY   = 16'hA001,
  parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic absorb,
  input  logic data_bit,
  input  logic drain,
  output logic crc_bit
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb      = crc_q[0] ^ data_bit;
  assign crc_bit = ~crc_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= PRESET;
    else if (init)   crc_q <= PRESET;
    else if (absorb) crc_q <= (crc_q >> 1) ^ (fb ? POLY : '0);
    else if (drain)  crc_q <= {1'b1, crc_q[CRC_W-1:1]};
  end

  // R6
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == PRESET));
endmodule

// File: rtl/pkt_line_enc.sv
module pkt_line_enc #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_in,
  output logic line
);
  always_ff @(posedge clk) begin
    if (!rst_n)             line <= IDLE_LEVEL;
    else if (en && !bit_in) line <= ~line;
  end

  // R2
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(line));
  // R2
  line_zero_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_in) |=> (line != $past(line)));
endmodule

// File: rtl/pkt_tx_ctrl.sv
module pkt_tx_ctrl
  import pkt_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CRC_W     = 16,
  parameter int MAX_BYTES = 64,
  parameter int LEN_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] pid,
  input  logic [LEN_W-1:0]  len,
  input  logic              bit_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              len_err,
  input  logic              crc_bit,
  output logic              crc_init,
  output logic              crc_absorb,
  output logic              crc_drain,
  output logic              shift_en,
  output logic              tx_bit
);
  localparam int CNT_W = $clog2(CRC_W);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_W - 1);
  localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(MAX_BYTES);

  tx_state_t         state;
  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] pid_q;
  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  left;
  logic              sending;
  logic              field_last;
  logic              too_long;

  assign sending    = (state == ST_SYNC) || (state == ST_PID) ||
                      (state == ST_DATA) || (state == ST_CRC);
  assign shift_en   = bit_en && sending;
  assign field_last = (state == ST_CRC) ? (cnt == CRC_LAST) : (cnt == BYTE_LAST);
  assign tx_bit     = (state == ST_CRC) ? crc_bit : sr[0];
  assign too_long   = (len > LEN_MAX);
  assign crc_init   = (state == ST_IDLE) && start && !too_long;
  assign crc_absorb = shift_en && (state == ST_DATA);
  assign crc_drain  = shift_en && (state == ST_CRC);
  assign in_ready   = (state == ST_LOAD);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sr      <= '0;
      pid_q   <= '0;
      cnt     <= '0;
      left    <= '0;
      done    <= 1'b0;
      len_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      len_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (too_long) begin
              len_err <= 1'b1;
            end else begin
              state <= ST_SYNC;
              sr    <= SYNC_PATTERN;
              pid_q <= pid;
              left  <= len;
              cnt   <= '0;
            end
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            sr    <= in_data;
            left  <= left - 1'b1;
            cnt   <= '0;
            state <= ST_DATA;
          end
        end
        ST_SYNC, ST_PID, ST_DATA, ST_CRC: begin
          if (bit_en) begin
            sr  <= sr >> 1;
            cnt <= cnt + 1'b1;
            if (field_last) begin
              cnt <= '0;
              case (state)
                ST_SYNC: begin
                  state <= ST_PID;
                  sr    <= pid_q;
                end
                ST_CRC: begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
                end
                default: state <= (left == '0) ? ST_CRC : ST_LOAD;
              endcase
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (!busy && !in_ready));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !len_err);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);
endmodule

// File: rtl/bitstream_pkt_tx.sv
module bitstream_pkt_tx
  import pkt_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 64,
  parameter int CRC_W     = 16,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] pid,
  input  logic [LEN_W-1:0]  len,
  input  logic              bit_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              line_out,
  output logic              busy,
  output logic              done,
  output logic              len_err
);
  logic crc_bit, crc_init, crc_absorb, crc_drain, shift_en, tx_bit;

  pkt_tx_ctrl #(
    .DATA_W(DATA_W), .CRC_W(CRC_W), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .pid(pid), .len(len),
    .bit_en(bit_en), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .busy(busy), .done(done), .len_err(len_err),
    .crc_bit(crc_bit), .crc_init(crc_init), .crc_absorb(crc_absorb),
    .crc_drain(crc_drain), .shift_en(shift_en), .tx_bit(tx_bit)
  );

  pkt_crc16 #(
    .CRC_W(CRC_W), .POLY(CRC_POLY_REFL), .PRESET(CRC_PRESET)
  ) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .absorb(crc_absorb),
    .data_bit(tx_bit), .drain(crc_drain), .crc_bit(crc_bit)
  );

  pkt_line_enc #(.IDLE_LEVEL(1'b1)) u_enc (
    .clk(clk), .rst_n(rst_n), .en(shift_en), .bit_in(tx_bit), .line(line_out)
  );

  // R9
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(line_out));
endmodule

// File: tb/bitstream_pkt_tx_tb.sv
module bitstream_pkt_tx_tb;
  localparam int LEN_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] pid = '0;
  logic [LEN_W-1:0] len = '0;
  logic bit_en = 1'b0;
  logic feed_en = 1'b0;
  logic clr = 1'b0;
  logic in_valid, in_ready, line_out, busy, done, len_err;
  logic [7:0] in_data;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  logic [7:0] pay [0:63];
  int hs;
  assign in_valid = feed_en;
  assign in_data  = pay[hs[5:0]];

  always @(posedge clk) begin
    if (clr) hs <= 0;
    else if (in_valid && in_ready) hs <= hs + 1;
  end

  bitstream_pkt_tx u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pid(pid), .len(len),
    .bit_en(bit_en), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .line_out(line_out), .busy(busy), .done(done),
    .len_err(len_err)
  );

  // {pid[18:11], len[10:4], mode[3:2], stall[1], poke[0]}
  localparam logic [18:0] VEC [0:5] = '{
    {8'hC3, 7'd0,  2'd0, 1'b0, 1'b0},
    {8'h4B, 7'd1,  2'd0, 1'b0, 1'b0},
    {8'hD2, 7'd3,  2'd1, 1'b0, 1'b1},
    {8'h5A, 7'd17, 2'd2, 1'b1, 1'b0},
    {8'h69, 7'd64, 2'd2, 1'b0, 1'b0},
    {8'hE1, 7'd2,  2'd3, 1'b0, 1'b0}
  };

  logic exp_bits [0:543];
  logic model_line;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++)
        c = ((c[0] ^ pay[i][j]) != 1'b0) ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    return ~c;
  endfunction

  task automatic run_pkt(input int v);
    logic [7:0] p;
    int n, mode, nbits, m_sync, m_pid, m_pay, m_crc, first_k;
    bit stall, poke;
    logic [15:0] c;
    p = VEC[v][18:11];
    n = int'(VEC[v][10:4]);
    mode = int'(VEC[v][3:2]);
    stall = VEC[v][1];
    poke = VEC[v][0];
    for (int i = 0; i < 64; i++)
      case (mode)
        0: pay[i] = 8'h00;
        1: pay[i] = 8'hFF;
        2: pay[i] = 8'((i * 29 + 7) & 255);
        default: pay[i] = i[0] ? 8'hAA : 8'h55;
      endcase
    c = ref_crc(n);
    for (int i = 0; i < 8; i++) begin
      exp_bits[i] = (i == 0);
      exp_bits[8 + i] = p[i];
    end
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++) exp_bits[16 + 8 * b + i] = pay[b][i];
    for (int i = 0; i < 16; i++) exp_bits[16 + 8 * n + i] = c[i];
    nbits = 32 + 8 * n;

    // R9: line starts from previous packet's final level
    chk(line_out === model_line, "R9 start level", int'(line_out), int'(model_line));

    clr = 1'b1; feed_en = !stall; start = 1'b1; pid = p; len = LEN_W'(n);
    @(negedge clk);
    clr = 1'b0; start = 1'b0;
    chk(busy === 1'b1, "R12/R7 accepted busy", int'(busy), 1);

    m_sync = 0; m_pid = 0; m_pay = 0; m_crc = 0; first_k = -1;
    for (int k = 0; k < nbits; k++) begin
      if (stall && k == 16) begin
        for (int s = 0; s < 5; s++) begin
          bit_en = 1'b1;
          @(negedge clk);
          bit_en = 1'b0;
          chk(line_out === model_line && in_ready === 1'b1, "R11 underrun hold",
              int'({in_ready, line_out}), int'({1'b1, model_line}));
          @(negedge clk);
        end
        feed_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
      end
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      model_line = model_line ^ ~exp_bits[k];
      if (line_out !== model_line) begin
        if (first_k < 0) first_k = k;
        if (k < 8) m_sync++;
        else if (k < 16) m_pid++;
        else if (k < 16 + 8 * n) m_pay++;
        else m_crc++;
        model_line = line_out;
      end
      if (k == nbits - 1)
        chk(done === 1'b1 && busy === 1'b0, "R8 done with busy fall",
            int'({done, busy}), 2);
      @(negedge clk);
      if (poke && k == 3) begin
        start = 1'b1; len = 7'd100; pid = 8'h00;
      end
      @(negedge clk);
      if (poke && k == 3) begin
        start = 1'b0;
        chk(len_err === 1'b0 && busy === 1'b1, "R10 start ignored while busy",
            int'({len_err, busy}), 1);
      end
    end
    chk(m_sync == 0, "R3 sync field", m_sync, 0);
    chk(m_pid == 0, "R4 identifier field", m_pid, 0);
    chk(m_pay == 0, "R5/R2 payload bits", m_pay, 0);
    chk(m_crc == 0, "R6 crc field", m_crc, 0);
    if (first_k >= 0) $display("  first mismatching bit index %0d in vector %0d", first_k, v);
    chk(done === 1'b0, "R8 done single cycle", int'(done), 0);
    chk(hs == n, "R5 handshake count", hs, n);
    if (n == 0) chk(busy === 1'b0 && m_crc == 0, "R12 empty payload packet", int'(busy), 0);
    feed_en = 1'b0;
  endtask

  task automatic bad_len(input logic [LEN_W-1:0] l);
    start = 1'b1; len = l; pid = 8'hA5;
    @(negedge clk);
    start = 1'b0;
    chk(len_err === 1'b1 && busy === 1'b0, "R7 error pulse", int'({len_err, busy}), 2);
    @(negedge clk);
    chk(len_err === 1'b0, "R7 error single cycle", int'(len_err), 0);
    for (int s = 0; s < 3; s++) begin
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      @(negedge clk);
    end
    chk(line_out === model_line && busy === 1'b0, "R7 nothing sent",
        int'({busy, line_out}), int'({1'b0, model_line}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clr = 1'b1;
    for (int i = 0; i < 64; i++) pay[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clr = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(line_out === 1'b1, "R1 line idle high", int'(line_out), 1);
    chk(busy === 1'b0 && done === 1'b0 && in_ready === 1'b0 && len_err === 1'b0,
        "R1 control outputs low", int'({busy, done, in_ready, len_err}), 0);
    model_line = 1'b1;

    for (int v = 0; v < 6; v++) run_pkt(v);

    bad_len(7'd65);
    bad_len(7'd127);
    run_pkt(1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule